// File: doc/BRIEF.md
# External Interrupt Flag Controller

This block turns two active-low external interrupt request pins into two pending flags that an interrupt controller reads. Each pin is first brought into the clock domain by a synchronizer. The synchronized level then drives that channel's flag in one of two trigger modes.

In edge mode, a high-to-low transition on the pin latches the flag. The flag stays set until the processor acknowledges that it has vectored to that channel. Software can also write the flag. In level mode, the flag simply mirrors the pin: it is set while the synchronized pin is low and clear while it is high.

The trigger mode of each channel sits in a small register loaded through a write strobe. Software can write the flags directly. Priority resolution, enable masking and vectoring belong to the surrounding controller.

Top module: `extint_flag_ctrl`

## Requirements
- R1: A synchronous active-high reset clears both pending flags and puts both channels in level mode (trig_mode bit = 0). The synchronizers are preset to the idle-high pin state.
- R2: Each request pin passes through a two-stage synchronizer. A pin change driven before rising edge k shows on pend_flag after rising edge k+2, and not before.
- R3: In edge mode (trig_mode bit = 1), a falling edge sets the flag. A falling edge is a previous synchronized sample of 1 followed by a current sample of 0. The flag stays set after the pin returns high.
- R4: In edge mode, vec_ack[i] clears flag i on the next rising edge and leaves the other channel's flag unchanged.
- R5: In edge mode, when a falling edge and vec_ack arrive in the same cycle, the set wins and the flag is 1.
- R6: In level mode, the flag is 1 while the synchronized pin is low and 0 while it is high, with no latching.
- R7: In level mode, vec_ack has no effect on the flag.
- R8: In edge mode, flag_wr[i] loads flag_wdata[i] into flag i, and the flag then holds that value. A software write beats a same-cycle acknowledge, and a same-cycle falling edge beats the software write.
- R9: In level mode, a software write shows on the flag for one cycle. On the following edge the pin state overrides it.
- R10: When mode_wr is high, mode_wdata is loaded into the trigger-mode register on the next rising edge. Bit i selects channel i: 1 is edge mode, 0 is level mode. The register is visible on trig_mode.
- R11: In edge mode, a pin held low after an acknowledge does not set the flag again. Only a new falling edge does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | 2 | Asynchronous active-low request pins, bit i = channel i |
| mode_wr | input | 1 | Trigger-mode register write strobe |
| mode_wdata | input | 2 | New trigger modes (1 = edge, 0 = level) |
| vec_ack | input | 2 | Per-channel vector-taken acknowledge strobes |
| flag_wr | input | 2 | Per-channel software flag write strobes |
| flag_wdata | input | 2 | Software flag write values |
| pend_flag | output | 2 | Pending interrupt flags |
| trig_mode | output | 2 | Current trigger mode per channel |

## Verification
A change on a request pin reaches pend_flag three rising edges after it is driven. Acknowledges, software writes and mode writes take effect one edge after they are driven. The bench changes inputs only on falling clock edges and samples outputs at the next falling edge. Each directed check steps a counted number of edges that matches these latencies, and it also checks the flag one and two edges early to confirm nothing arrives sooner. A cycle-accurate model built from the requirements is compared every cycle during a sweep over all input combinations in all four mode settings.

// File: rtl/extint_pkg.sv
package extint_pkg;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_mode_e;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_SET,
        OP_CLEAR,
        OP_WRITE,
        OP_TRACK
    } flag_op_e;

    typedef struct packed {
        logic wr;
        logic data;
    } sw_write_t;

    // A high-to-low step between two consecutive synchronized samples.
    function automatic logic is_falling(input logic prev, input logic cur);
        return prev & ~cur;
    endfunction

    // Priority: in edge mode, new edge > software write > acknowledge > hold.
    // In level mode, software write > pin tracking.
    function automatic flag_op_e pick_op(input trig_mode_e mode,
                                         input logic fall,
                                         input logic wr,
                                         input logic ack);
        flag_op_e op;
        if (mode == TRIG_EDGE) begin
            if (fall)      op = OP_SET;
            else if (wr)   op = OP_WRITE;
            else if (ack)  op = OP_CLEAR;
            else           op = OP_HOLD;
        end else begin
            if (wr)        op = OP_WRITE;
            else           op = OP_TRACK;
        end
        return op;
    endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= IDLE;
                else     chain <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{IDLE}};
                else     chain <= {chain[LAST-1:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain[LAST];

endmodule

// File: rtl/extint_edge_det.sv
module extint_edge_det
    import extint_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sample,
    output logic fall,
    output logic level_active
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= sample;
    end

    assign fall         = is_falling(prev_q, sample);
    assign level_active = ~sample;

    // A detected edge lasts exactly one cycle.
    assert_single_fall_R3: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);

endmodule

// File: rtl/extint_flag_cell.sv
module extint_flag_cell
    import extint_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  trig_mode_e mode,
    input  logic       fall,
    input  logic       level_active,
    input  logic       ack,
    input  sw_write_t  sw,
    output logic       flag
);
    flag_op_e op;

    assign op = pick_op(mode, fall, sw.wr, ack);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else begin
            case (op)
                OP_SET:   flag <= 1'b1;
                OP_CLEAR: flag <= 1'b0;
                OP_WRITE: flag <= sw.data;
                OP_TRACK: flag <= level_active;
                default:  flag <= flag;
            endcase
        end
    end

    assert_edge_set_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == TRIG_EDGE && fall) |=> flag);

    assert_ack_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == TRIG_EDGE && ack && !fall && !sw.wr) |=> !flag);

    assert_set_beats_ack_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == TRIG_EDGE && fall && ack) |=> flag);

    assert_level_low_sets_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == TRIG_LEVEL && level_active && !sw.wr) |=> flag);

    assert_level_ack_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == TRIG_LEVEL && !level_active && ack && !sw.wr) |=> !flag);

    assert_sw_write_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == TRIG_EDGE && !fall && sw.wr) |=> flag == $past(sw.data));

    assert_edge_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mode == TRIG_EDGE && !fall && !sw.wr && !ack) |=> $stable(flag));

endmodule

// File: rtl/extint_flag_ctrl.sv
module extint_flag_ctrl
    import extint_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] irq_n,
    input  logic              mode_wr,
    input  logic [NUM_CH-1:0] mode_wdata,
    input  logic [NUM_CH-1:0] vec_ack,
    input  logic [NUM_CH-1:0] flag_wr,
    input  logic [NUM_CH-1:0] flag_wdata,
    output logic [NUM_CH-1:0] pend_flag,
    output logic [NUM_CH-1:0] trig_mode
);
    localparam int CH_LAST = NUM_CH - 1;

    logic [CH_LAST:0] mode_q;
    logic [CH_LAST:0] pin_sync;
    logic [CH_LAST:0] fall;
    logic [CH_LAST:0] level_active;

    always_ff @(posedge clk) begin
        if (rst)          mode_q <= '0;
        else if (mode_wr) mode_q <= mode_wdata;
    end

    assign trig_mode = mode_q;

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            sw_write_t sw;
            assign sw.wr   = flag_wr[ch];
            assign sw.data = flag_wdata[ch];

            extint_sync #(
                .STAGES (SYNC_STAGES),
                .IDLE   (1'b1)
            ) u_sync (
                .clk      (clk),
                .rst      (rst),
                .async_in (irq_n[ch]),
                .sync_out (pin_sync[ch])
            );

            extint_edge_det u_edge (
                .clk          (clk),
                .rst          (rst),
                .sample       (pin_sync[ch]),
                .fall         (fall[ch]),
                .level_active (level_active[ch])
            );

            extint_flag_cell u_flag (
                .clk          (clk),
                .rst          (rst),
                .mode         (trig_mode_e'(mode_q[ch])),
                .fall         (fall[ch]),
                .level_active (level_active[ch]),
                .ack          (vec_ack[ch]),
                .sw           (sw),
                .flag         (pend_flag[ch])
            );
        end
    endgenerate

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (pend_flag == '0 && trig_mode == '0));

    assert_mode_load_R10: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> trig_mode == $past(mode_wdata));

endmodule

// File: tb/extint_flag_ctrl_tb.sv
module extint_flag_ctrl_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] irq_n = 2'b11;
    logic       mode_wr = 1'b0;
    logic [1:0] mode_wdata = 2'b00;
    logic [1:0] vec_ack = 2'b00;
    logic [1:0] flag_wr = 2'b00;
    logic [1:0] flag_wdata = 2'b00;
    logic [1:0] pend_flag;
    logic [1:0] trig_mode;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    extint_flag_ctrl dut_i (
        .clk        (clk),
        .rst        (rst),
        .irq_n      (irq_n),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .vec_ack    (vec_ack),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .pend_flag  (pend_flag),
        .trig_mode  (trig_mode)
    );

    // Reference model written from the requirements: 2-stage sync, one sample of history.
    logic [1:0] m_s1, m_s2, m_prev, m_flag, m_mode;

    function automatic logic next_flag(input logic edge_m, input logic prev, input logic cur,
                                       input logic wr, input logic wd, input logic ack,
                                       input logic old);
        if (edge_m) begin
            if (prev && !cur) return 1'b1;
            if (wr)           return wd;
            if (ack)          return 1'b0;
            return old;
        end
        if (wr) return wd;
        return !cur;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= 2'b11; m_s2 <= 2'b11; m_prev <= 2'b11;
            m_flag <= 2'b00; m_mode <= 2'b00;
        end else begin
            m_s1 <= irq_n;
            m_s2 <= m_s1;
            m_prev <= m_s2;
            if (mode_wr) m_mode <= mode_wdata;
            for (int i = 0; i < 2; i++)
                m_flag[i] <= next_flag(m_mode[i], m_prev[i], m_s2[i], flag_wr[i],
                                       flag_wdata[i], vec_ack[i], m_flag[i]);
        end
    end

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        irq_n = 2'b11; mode_wr = 0; vec_ack = 0; flag_wr = 0; flag_wdata = 0;
        repeat (3) tick();
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        tick();
        check("R1 flags", pend_flag, 2'b00);
        check("R1 mode", trig_mode, 2'b00);

        mode_wr = 1; mode_wdata = 2'b11;
        tick();
        mode_wr = 0;
        check("R10 mode load", trig_mode, 2'b11);

        irq_n[0] = 1'b0;
        tick(); check("R2 early edge 1", pend_flag, 2'b00);
        tick(); check("R2 early edge 2", pend_flag, 2'b00);
        tick(); check("R2 R3 edge set", pend_flag, 2'b01);
        irq_n[0] = 1'b1;
        repeat (4) tick();
        check("R3 latched after release", pend_flag, 2'b01);

        vec_ack = 2'b01;
        tick();
        vec_ack = 2'b00;
        check("R4 ack clears ch0 only", pend_flag, 2'b00);

        irq_n[0] = 1'b0;
        repeat (3) tick();
        check("R3 new edge", pend_flag, 2'b01);
        vec_ack = 2'b01;
        tick();
        vec_ack = 2'b00;
        check("R4 ack with pin low", pend_flag, 2'b00);
        repeat (5) tick();
        check("R11 no reset while held low", pend_flag, 2'b00);

        irq_n[0] = 1'b1;
        repeat (4) tick();
        irq_n[0] = 1'b0;
        tick(); tick();
        vec_ack = 2'b01;
        tick();
        vec_ack = 2'b00;
        check("R5 set beats ack", pend_flag, 2'b01);

        flag_wr = 2'b01; flag_wdata = 2'b00;
        tick();
        check("R8 sw clear", pend_flag, 2'b00);
        flag_wr = 2'b01; flag_wdata = 2'b01; vec_ack = 2'b01;
        tick();
        flag_wr = 0; flag_wdata = 0; vec_ack = 0;
        check("R8 sw beats ack", pend_flag, 2'b01);
        repeat (3) tick();
        check("R8 sw value held", pend_flag, 2'b01);

        flag_wr = 2'b10; flag_wdata = 2'b10;
        tick();
        flag_wr = 0; flag_wdata = 0;
        check("R8 sw set ch1", pend_flag, 2'b11);
        vec_ack = 2'b10;
        tick();
        vec_ack = 0;
        check("R4 ack clears ch1 only", pend_flag, 2'b01);

        mode_wr = 1; mode_wdata = 2'b00;
        tick();
        mode_wr = 0;
        check("R10 mode back to level", trig_mode, 2'b00);
        tick();
        check("R6 level low", pend_flag, 2'b01);
        vec_ack = 2'b01;
        tick();
        vec_ack = 0;
        check("R7 ack ignored", pend_flag, 2'b01);
        irq_n[0] = 1'b1;
        tick(); tick();
        check("R2 R6 still low at edge 2", pend_flag, 2'b01);
        tick();
        check("R6 level high", pend_flag, 2'b00);
        flag_wr = 2'b01; flag_wdata = 2'b01;
        tick();
        flag_wr = 0; flag_wdata = 0;
        check("R9 write visible", pend_flag, 2'b01);
        tick();
        check("R9 pin overrides", pend_flag, 2'b00);

        // Sweep: every combination of pins, acks and writes in every mode setting.
        for (int m = 0; m < 4; m++) begin
            do_reset();
            mode_wr = 1; mode_wdata = m[1:0];
            tick();
            mode_wr = 0;
            check("R1 R10 sweep mode", trig_mode, m[1:0]);
            for (int v = 0; v < 256; v++) begin
                irq_n = v[1:0]; vec_ack = v[3:2]; flag_wr = v[5:4]; flag_wdata = v[7:6];
                for (int h = 0; h < (v % 3) + 1; h++) begin
                    tick();
                    vec_ack = 0; flag_wr = 0;
                    check("R2 R3 R4 R5 R6 R7 R8 R9 R11 sweep", pend_flag, m_flag);
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule